// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block is the clock master of a serial audio port. From the system clock it derives a bit clock through a programmable divider and a one-bit-wide frame-sync pulse that marks the first bit of every frame. A frame is a fixed number of slots times a fixed word length, all counted in bit clocks. A separate output can carry an oversampling clock, at half the system clock rate, to an external converter.

A transmit enable starts the clocks. A latched stop policy decides what happens after the enable is cleared. With policy 0 the clocks run on with no data to move. With policy 1 they halt exactly at the end of a frame, so no partial frame ever appears on the pins. Software may change the policy only while the port is disabled. An idle-level input sets the resting level of the bit clock. Each bit starts at that level and moves away from it halfway through. That mid-bit edge is the data launch edge: it is rising for idle level 0 and falling for idle level 1.

A four-state machine controls the clocks. ST_IDLE has the clocks stopped and the counters cleared. ST_RUN is enabled operation. ST_FREE runs on after a disable under policy 0. ST_DRAIN runs out the current frame under policy 1. The transitions are:
- start: ST_IDLE to ST_RUN when the enable is high.
- run-on: ST_RUN or ST_DRAIN to ST_FREE when the enable is low and the policy is 0.
- drain: ST_RUN or ST_FREE to ST_DRAIN when the enable is low and the policy is 1.
- halt: ST_RUN, ST_FREE or ST_DRAIN to ST_IDLE when the policy is 1 and the frame boundary arrives in that cycle.
- resume: any running state to ST_RUN when the enable returns.

Top module: `audio_clkgen`

## Requirements
- R1: After reset, clk_running, fsync and mclk_out are 0, stop_policy is 0, and bclk equals idle_high.
- R2: When tx_en is seen high at a clock edge in the idle state, clk_running is 1 from that edge on. The first running cycle is bit 0 of a frame.
- R3: While running, bclk has a period of 2*(div+1) system clocks. It holds idle_high for the first div+1 cycles of each bit and the inverted level for the remaining div+1.
- R4: A frame lasts SLOTS*WORDLEN bit periods. fsync is high for exactly the first bit period of each frame and is never high while the clocks are stopped.
- R5: With stop_policy 0, clearing tx_en leaves bclk and fsync running with the same pattern, for as long as the enable stays low.
- R6: With stop_policy 1, after the first edge that sees tx_en low, the clocks run to the next frame boundary. The last running cycle is the last cycle of a frame. clk_running drops on the following cycle, and bclk returns to idle_high with fsync low.
- R7: If stop_policy becomes 1 while the clocks are running on with tx_en low, they stop at the next frame boundary under the rule of R6. The policy is re-evaluated each cycle while disabled.
- R8: A pulse on stop_wr loads stop_val into stop_policy only when tx_en is low. A pulse while tx_en is high leaves stop_policy unchanged.
- R9: While stopped, bclk follows idle_high.
- R10: When os_en, master_mode, sync_mode and int_clk are all 1, mclk_out inverts on every system clock, starting at 1 on the first edge. When any of them is 0, mclk_out is 0 from the next edge on.
- R11: Raising tx_en again while draining cancels the stop. The clocks continue without a break in the bclk or fsync pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| stop_wr | input | 1 | Write strobe for the stop policy |
| stop_val | input | 1 | Policy value to write (1 = halt at frame boundary) |
| idle_high | input | 1 | Bit-clock idle level |
| div | input | DIV_W | Divider setting; bit period is 2*(div+1) clocks |
| os_en | input | 1 | Oversampling clock output enable |
| master_mode | input | 1 | Port is clock master |
| sync_mode | input | 1 | Transmit and receive share clocks |
| int_clk | input | 1 | Transmit clock generated internally |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync, one bit period per frame |
| mclk_out | output | 1 | Oversampling clock, or 0 when not permitted |
| clk_running | output | 1 | Clocks are active |
| stop_policy | output | 1 | Latched stop policy |

## Verification
The bench stops the clocks at random points in a frame, including the first and last cycle of a frame, over random divider values. A design that cut the frame short, or added a frame too many, would show a wrong last running cycle. The bench writes the policy while enabled and then disables the port. A design that accepted that write would halt instead of running on. It also sets the policy during a run-on, where a design that ignored the policy while disabled would never stop, and it re-enables during a drain, where a design that committed to the stop would drop the clocks. The oversampling enables are removed one at a time, so a gate that ignored any single condition would keep toggling.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FREE  = 2'd2,
        ST_DRAIN = 2'd3
    } clk_state_t;
endpackage

// File: rtl/audio_bclk_div.sv
module audio_bclk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             bit_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic             half_tick;

    assign half_tick = run && (cnt_q >= div);
    assign bit_tick  = half_tick && phase_q;
    assign phase     = phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (half_tick) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R3: the half-bit level changes only on a divider wrap
    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !half_tick) |=> $stable(phase_q));
endmodule

// File: rtl/audio_frame_ctr.sv
module audio_frame_ctr #(
    parameter int FRAME_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_tick,
    output logic fsync,
    output logic frame_end
);
    localparam int CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
    localparam bit POW2 = (FRAME_BITS == (1 << CW));

    logic [CW-1:0] bit_q;

    assign frame_end = bit_tick && (bit_q == LAST_BIT);
    assign fsync     = run && (bit_q == '0);

    generate
        if (POW2) begin : g_wrap
            always_ff @(posedge clk) begin
                if (!rst_n || !run) bit_q <= '0;
                else if (bit_tick)  bit_q <= bit_q + 1'b1;
            end
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (!rst_n || !run)  bit_q <= '0;
                else if (frame_end)  bit_q <= '0;
                else if (bit_tick)   bit_q <= bit_q + 1'b1;
            end
        end
    endgenerate

    // R4: the bit index never leaves the frame
    assert_bit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= LAST_BIT);
endmodule

// File: rtl/audio_clk_fsm.sv
module audio_clk_fsm
    import audio_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic stop_cfg,
    input  logic frame_end,
    output logic running
);
    clk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_en) state_d = ST_RUN;
            ST_RUN, ST_FREE, ST_DRAIN: begin
                if (tx_en)          state_d = ST_RUN;
                else if (!stop_cfg) state_d = ST_FREE;
                else if (frame_end) state_d = ST_IDLE;
                else                state_d = ST_DRAIN;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running = (state_q != ST_IDLE);
    end

    // R2: enable in idle starts the clocks on the next edge
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && tx_en) |=> running);
    // R5: policy 0 never lets the clocks stop
    assert_run_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop_cfg) |=> running);
    // R6: clocks only stop right after a frame boundary
    assert_stop_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(frame_end));
endmodule

// File: rtl/audio_os_clk.sv
module audio_os_clk (
    input  logic clk,
    input  logic rst_n,
    input  logic permit,
    output logic os_clk
);
    logic os_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !permit) os_q <= 1'b0;
        else                   os_q <= ~os_q;
    end

    assign os_clk = os_q;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
    parameter int DIV_W   = 4,
    parameter int SLOTS   = 2,
    parameter int WORDLEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             stop_wr,
    input  logic             stop_val,
    input  logic             idle_high,
    input  logic [DIV_W-1:0] div,
    input  logic             os_en,
    input  logic             master_mode,
    input  logic             sync_mode,
    input  logic             int_clk,
    output logic             bclk,
    output logic             fsync,
    output logic             mclk_out,
    output logic             clk_running,
    output logic             stop_policy
);
    localparam int FRAME_BITS = SLOTS * WORDLEN;

    logic policy_q;
    logic running;
    logic phase;
    logic bit_tick;
    logic frame_end;
    logic os_permit;

    always_ff @(posedge clk) begin
        if (!rst_n)                 policy_q <= 1'b0;
        else if (stop_wr && !tx_en) policy_q <= stop_val;
    end

    audio_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .div      (div),
        .phase    (phase),
        .bit_tick (bit_tick)
    );

    audio_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .bit_tick  (bit_tick),
        .fsync     (fsync),
        .frame_end (frame_end)
    );

    audio_clk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .stop_cfg  (policy_q),
        .frame_end (frame_end),
        .running   (running)
    );

    assign os_permit = os_en && master_mode && sync_mode && int_clk;

    audio_os_clk u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .permit (os_permit),
        .os_clk (mclk_out)
    );

    assign bclk        = idle_high ^ (running && phase);
    assign clk_running = running;
    assign stop_policy = policy_q;

    // R8: policy is frozen while the port is enabled
    assert_policy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> $stable(stop_policy));
    // R9: a stopped bit clock rests at the idle level
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_running |-> (bclk == idle_high));
    // R4: no frame-sync while stopped
    assert_fsync_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> clk_running);
    // R10: a missing permission silences the oversampling clock
    assert_os_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(os_en && master_mode && sync_mode && int_clk) |=> !mclk_out);
endmodule

// File: tb/tb_audio_clkgen.sv
module tb_audio_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 4;
    localparam int SLOTS      = 2;
    localparam int WORDLEN    = 16;
    localparam int FRAME      = SLOTS * WORDLEN;

    logic             clk = 1'b0;
    logic             rst_n, tx_en, stop_wr, stop_val, idle_high;
    logic [DIV_W-1:0] div;
    logic             os_en, master_mode, sync_mode, int_clk;
    logic             bclk, fsync, mclk_out, clk_running, stop_policy;

    int checks = 0;
    int errors = 0;
    int n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_clkgen #(.DIV_W(DIV_W), .SLOTS(SLOTS), .WORDLEN(WORDLEN)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .stop_wr(stop_wr),
        .stop_val(stop_val), .idle_high(idle_high), .div(div), .os_en(os_en),
        .master_mode(master_mode), .sync_mode(sync_mode), .int_clk(int_clk),
        .bclk(bclk), .fsync(fsync), .mclk_out(mclk_out),
        .clk_running(clk_running), .stop_policy(stop_policy)
    );

    function automatic int exp_bclk(int idx, int d, int idl);
        return idl ^ ((idx / (d + 1)) % 2);
    endfunction

    function automatic int exp_fsync(int idx, int d);
        return (((idx / (2 * (d + 1))) % FRAME) == 0) ? 1 : 0;
    endfunction

    function automatic int frame_cycles(int d);
        return 2 * (d + 1) * FRAME;
    endfunction

    function automatic int exp_last(int from_c, int d);
        int p = frame_cycles(d);
        return (from_c / p) * p + p - 1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, n);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        n++;
    endtask

    task automatic check_pos(int d, int idl, string tag);
        check(tag, int'(bclk), exp_bclk(n, d, idl));
        check(tag, int'(fsync), exp_fsync(n, d));
    endtask

    task automatic begin_run(int d, int idl);
        div       = DIV_W'(d);
        idle_high = idl[0];
        tx_en     = 1'b1;
        @(negedge clk);
        n = 0;
        check("R2", int'(clk_running), 1);
    endtask

    task automatic write_policy(bit v);
        stop_wr  = 1'b1;
        stop_val = v;
        @(negedge clk);
        n++;
        stop_wr  = 1'b0;
    endtask

    task automatic drain_to_stop(int d, int idl, int from_c, string tag);
        int last = n;
        int guard = n + 2 * frame_cycles(d) + 8;
        adv();
        while (clk_running && n < guard) begin
            check_pos(d, idl, tag);
            last = n;
            adv();
        end
        check(tag, last, exp_last(from_c, d));
        check(tag, int'(clk_running), 0);
        check(tag, int'(fsync), 0);
        check("R9", int'(bclk), idl);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        rst_n = 1'b0; tx_en = 1'b0; stop_wr = 1'b0; stop_val = 1'b0;
        idle_high = 1'b0; div = '0;
        os_en = 1'b0; master_mode = 1'b0; sync_mode = 1'b0; int_clk = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", int'(clk_running), 0);
        check("R1", int'(fsync), 0);
        check("R1", int'(mclk_out), 0);
        check("R1", int'(stop_policy), 0);
        check("R1", int'(bclk), 0);

        // R9 idle level follows input while stopped
        idle_high = 1'b1;
        @(negedge clk);
        check("R9", int'(bclk), 1);
        idle_high = 1'b0;
        @(negedge clk);
        check("R9", int'(bclk), 0);

        // R8 writes accepted while disabled
        write_policy(1'b1);
        check("R8", int'(stop_policy), 1);
        write_policy(1'b0);
        check("R8", int'(stop_policy), 0);

        // R3/R4/R5/R7/R8 directed run-on sequence, div=1, idle 0
        begin
            int d = 1;
            int p = frame_cycles(d);
            int c2;
            begin_run(d, 0);
            for (int k = 0; k < 2 * p; k++) begin
                check_pos(d, 0, "R3/R4");
                if (k == 10) begin
                    stop_wr = 1'b1; stop_val = 1'b1;
                end
                if (k == 11) begin
                    stop_wr = 1'b0;
                    check("R8", int'(stop_policy), 0);
                end
                adv();
            end
            tx_en = 1'b0;
            for (int k = 0; k < 2 * p; k++) begin
                adv();
                check_pos(d, 0, "R5");
                check("R5", int'(clk_running), 1);
            end
            c2 = n;
            write_policy(1'b1);
            check("R8", int'(stop_policy), 1);
            check_pos(d, 0, "R7");
            drain_to_stop(d, 0, c2 + 1, "R7");
        end

        // R6 random trials, policy 1
        for (int t = 0; t < 8; t++) begin
            int d = $urandom % 16;
            int idl = $urandom % 2;
            int p = frame_cycles(d);
            int c;
            case (t)
                0: c = 0;
                1: c = p - 1;
                2: c = p;
                default: c = $urandom % (2 * p);
            endcase
            idle_high = idl[0];
            @(negedge clk);
            begin_run(d, idl);
            while (n < c) begin
                check_pos(d, idl, "R3/R4");
                adv();
            end
            check_pos(d, idl, "R3/R4");
            tx_en = 1'b0;
            drain_to_stop(d, idl, c, "R6");
        end

        // R11 re-enable during drain
        begin
            int d = 0;
            int p = frame_cycles(d);
            begin_run(d, 1);
            while (n < p + 3) begin
                check_pos(d, 1, "R11");
                adv();
            end
            tx_en = 1'b0;
            repeat (4) begin
                adv();
                check_pos(d, 1, "R11");
            end
            tx_en = 1'b1;
            while (n < 4 * p) begin
                adv();
                check("R11", int'(clk_running), 1);
                check_pos(d, 1, "R11");
            end
            tx_en = 1'b0;
            drain_to_stop(d, 1, n, "R6");
        end

        // R10 oversampling clock permission
        for (int i = 0; i < 4; i++) begin
            int prev;
            os_en = 1'b1; master_mode = 1'b1; sync_mode = 1'b1; int_clk = 1'b1;
            @(negedge clk);
            check("R10", int'(mclk_out), 1);
            prev = 1;
            repeat (6) begin
                @(negedge clk);
                check("R10", int'(mclk_out), 1 - prev);
                prev = 1 - prev;
            end
            case (i)
                0: os_en = 1'b0;
                1: master_mode = 1'b0;
                2: sync_mode = 1'b0;
                default: int_clk = 1'b0;
            endcase
            repeat (4) begin
                @(negedge clk);
                check("R10", int'(mclk_out), 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule